// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and arithmetic of a 32-bit processor that runs each instruction over several clock cycles. It holds the program counter, an instruction latch, two operand latches, a result latch, a memory-data latch, a 32-entry register file, one ALU and the selection multiplexers. Because the intermediate values are latched, one ALU and one memory port can be reused across the cycles of an instruction. The one port serves both instruction fetch and data access.

The block does no sequencing of its own. An external sequencer drives every latch enable and every multiplexer select on each cycle. The block returns the opcode and function fields of the latched instruction, plus the ALU zero flag, so the sequencer can choose its next step. The sequencer usually has the ALU compute the branch target during decode, before it knows whether the instruction is a branch. If a branch then turns out to be taken, the target is already in the result latch.

Top module: `mc_datapath`

## Requirements
- R1: When `ir_we` is high, the instruction latch takes the memory word at the PC. If `pc_we` is also high with `opa_from_reg`=0, `opb_sel`=01 (constant 4), `alu_ctl`=010 (add) and `pc_next_sel`=00 (ALU result), then the PC becomes PC+4 on that edge.
- R2: When `opnd_we` is high, operand latch A takes the register indexed by instruction bits [25:21], and operand latch B takes the register indexed by bits [20:16].
- R3: With `opa_from_reg`=0 and `opb_sel`=11, the ALU adds the PC to the sign-extended instruction bits [15:0] shifted left by two. When `res_we` is high, the result latch takes this sum.
- R4: With `opa_from_reg`=1, `opb_sel`=10 and add selected, the ALU adds A to the sign-extended instruction bits [15:0]. This forms a data address.
- R5: When `mdr_we` is high, the memory-data latch takes `mem_rdata`. With `rf_we` high, `wb_from_mdr`=1 and `dst_is_rd`=0, the latch value is then written to the register indexed by instruction bits [20:16].
- R6: `mem_write` drives `mem_we` on the same cycle. With `addr_from_res`=1, the word address is bits [31:2] of the result latch, and `mem_wdata` carries operand B.
- R7: With `rf_we` high, `wb_from_mdr`=0 and `dst_is_rd`=1, the result latch is written to the register indexed by instruction bits [15:11].
- R8: Register 0 always reads as zero. Writes to register 0 have no effect.
- R9: The ALU opcodes are `alu_ctl` 000 = AND, 001 = OR, 010 = add, 110 = subtract and 111 = signed set-less-than. Set-less-than returns 1 or 0. `alu_zero` is high when the ALU result is zero.
- R10: When `pc_cond_we` is high and `pc_next_sel`=01, the PC loads the result latch only if `alu_zero` is high. Otherwise the PC keeps its value.
- R11: When `pc_we` is high and `pc_next_sel`=10, the PC loads {PC[31:28], instruction bits [25:0], 2'b00}.
- R12: A synchronous active-high reset clears the PC, all latches and all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional PC load |
| pc_cond_we | input | 1 | PC load qualified by the ALU zero flag |
| ir_we | input | 1 | Instruction latch load |
| opnd_we | input | 1 | Operand latch A and B load |
| res_we | input | 1 | Result latch load |
| mdr_we | input | 1 | Memory-data latch load |
| rf_we | input | 1 | Register file write |
| mem_write | input | 1 | Memory write request |
| addr_from_res | input | 1 | Memory address select: 0 = PC, 1 = result latch |
| opa_from_reg | input | 1 | ALU A select: 0 = PC, 1 = operand A |
| opb_sel | input | 2 | ALU B select: 00 = B, 01 = 4, 10 = immediate, 11 = immediate shifted left by 2 |
| alu_ctl | input | 3 | ALU operation |
| pc_next_sel | input | 2 | PC source: 00 = ALU, 01 = result latch, 10 = jump address |
| wb_from_mdr | input | 1 | Write data select: 0 = result latch, 1 = memory-data latch |
| dst_is_rd | input | 1 | Destination select: 0 = bits [20:16], 1 = bits [15:11] |
| mem_word_addr | output | 30 | Word address to memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational on the address |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | ALU result is zero |
| pc_value | output | 32 | Current PC |

## Verification
The assertions assume that `mem_rdata` settles combinationally from `mem_word_addr` within the same cycle. They also assume that the sequencer never raises two conflicting loads of the PC with different intent. The PC-increment property applies only when the full fetch control pattern is present. The branch-hold property applies only when the unconditional PC load is low. The bench acts as a well-behaved sequencer and issues only legal step patterns for load, store, register-register, branch and jump. It keeps code below byte 512 and data in words 128 to 255 of a 256-word model memory, so the two regions never overlap.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned NREG    = 32;
    localparam int unsigned RIDX_W  = $clog2(NREG);
    localparam int unsigned WADDR_W = XLEN - 2;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG     = 2'b00,
        OPB_FOUR    = 2'b01,
        OPB_IMM     = 2'b10,
        OPB_IMM_SH2 = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCN_ALU    = 2'b00,
        PCN_TARGET = 2'b01,
        PCN_JUMP   = 2'b10,
        PCN_RSVD   = 2'b11
    } pc_next_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        fn;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc,
                                                  input logic [25:0] tgt);
        return {pc[XLEN-1:28], tgt, 2'b00};
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    // cell 0 is a constant zero; the rest are real storage
    assign cells[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (we && waddr == AW'(g))
                cells[g] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

    // R2
    rf_write_read_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (raddr_a != $past(waddr)) || (rdata_a == $past(wdata)));

    // R8
    r0_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (raddr_b != '0) || (rdata_b == '0));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    logic             subtract;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             lt;

    assign subtract = (op == ALU_SUB) || (op == ALU_SLT);
    assign b_eff    = subtract ? ~b : b;
    assign sum      = a + b_eff + WIDTH'(subtract);
    assign lt       = (a[WIDTH-1] != b[WIDTH-1]) ? a[WIDTH-1] : sum[WIDTH-1];

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, lt};
            default: y = sum;
        endcase
    end

    assign zero = (y == '0);

    // R9
    slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_SLT) |-> (y[WIDTH-1:1] == '0));

    // R9
    sub_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_SUB && a == b) |-> zero);

endmodule

// File: rtl/mc_operand_mux.sv
module mc_operand_mux
    import mc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             a_from_reg,
    input  opb_sel_e         b_sel,
    input  logic [WIDTH-1:0] pc,
    input  logic [WIDTH-1:0] reg_a,
    input  logic [WIDTH-1:0] reg_b,
    input  logic [15:0]      imm,
    output logic [WIDTH-1:0] src_a,
    output logic [WIDTH-1:0] src_b
);

    logic [WIDTH-1:0] imm_ext;

    assign imm_ext = sext16(imm);
    assign src_a   = a_from_reg ? reg_a : pc;

    always_comb begin
        case (b_sel)
            OPB_REG:  src_b = reg_b;
            OPB_FOUR: src_b = WIDTH'(4);
            OPB_IMM:  src_b = imm_ext;
            default:  src_b = imm_ext << 2;
        endcase
    end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pc_we,
    input  logic               pc_cond_we,
    input  logic               ir_we,
    input  logic               opnd_we,
    input  logic               res_we,
    input  logic               mdr_we,
    input  logic               rf_we,
    input  logic               mem_write,
    input  logic               addr_from_res,
    input  logic               opa_from_reg,
    input  logic [1:0]         opb_sel,
    input  logic [2:0]         alu_ctl,
    input  logic [1:0]         pc_next_sel,
    input  logic               wb_from_mdr,
    input  logic               dst_is_rd,
    output logic [WADDR_W-1:0] mem_word_addr,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic [5:0]         opcode,
    output logic [5:0]         funct,
    output logic               alu_zero,
    output logic [XLEN-1:0]    pc_value
);

    logic [XLEN-1:0] pc_q, a_q, b_q, res_q, mdr_q;
    instr_t          ir_q;
    logic [XLEN-1:0] rf_a, rf_b, src_a, src_b, alu_y, pc_next, wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic            pc_load;
    pc_next_e        pcn;

    assign pcn = pc_next_e'(pc_next_sel);

    mc_regfile #(.WIDTH(XLEN), .DEPTH(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .raddr_a(ir_q.rs), .raddr_b(ir_q.rt),
        .rdata_a(rf_a), .rdata_b(rf_b),
        .we(rf_we), .waddr(wb_idx), .wdata(wb_data)
    );

    mc_operand_mux #(.WIDTH(XLEN)) u_mux (
        .a_from_reg(opa_from_reg), .b_sel(opb_sel_e'(opb_sel)),
        .pc(pc_q), .reg_a(a_q), .reg_b(b_q),
        .imm({ir_q.rd, ir_q.shamt, ir_q.fn}),
        .src_a(src_a), .src_b(src_b)
    );

    mc_alu #(.WIDTH(XLEN)) u_alu (
        .clk(clk), .rst(rst), .op(alu_op_e'(alu_ctl)),
        .a(src_a), .b(src_b), .y(alu_y), .zero(alu_zero)
    );

    always_comb begin
        case (pcn)
            PCN_TARGET: pc_next = res_q;
            PCN_JUMP:   pc_next = jump_dest(pc_q, {ir_q.rs, ir_q.rt, ir_q.rd, ir_q.shamt, ir_q.fn});
            default:    pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_we || (pc_cond_we && alu_zero);
    assign wb_idx  = dst_is_rd ? ir_q.rd : ir_q.rt;
    assign wb_data = wb_from_mdr ? mdr_q : res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (pc_load) pc_q  <= pc_next;
            if (ir_we)   ir_q  <= instr_t'(mem_rdata);
            if (opnd_we) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (res_we)  res_q <= alu_y;
            if (mdr_we)  mdr_q <= mem_rdata;
        end
    end

    assign mem_word_addr = addr_from_res ? res_q[XLEN-1:2] : pc_q[XLEN-1:2];
    assign mem_we        = mem_write;
    assign mem_wdata     = b_q;
    assign opcode        = ir_q.op;
    assign funct         = ir_q.fn;
    assign pc_value      = pc_q;

    // R1
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_we && pc_we && !opa_from_reg && opb_sel == OPB_FOUR &&
         alu_ctl == ALU_ADD && pcn == PCN_ALU) |=> (pc_q == $past(pc_q) + 32'd4));

    // R5
    mdr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        mdr_we |=> (mdr_q == $past(mem_rdata)));

    // R10
    branch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_cond_we && !pc_we && !alu_zero) |=> $stable(pc_q));

    // R11
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pcn == PCN_JUMP) |=>
            (pc_q[31:28] == $past(pc_q[31:28]) && pc_q[1:0] == 2'b00));

endmodule

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic pc_we, pc_cond_we, ir_we, opnd_we, res_we, mdr_we, rf_we, mem_write;
    logic addr_from_res, opa_from_reg, wb_from_mdr, dst_is_rd;
    logic [1:0] opb_sel, pc_next_sel;
    logic [2:0] alu_ctl;
    logic [29:0] mem_word_addr;
    logic mem_we, alu_zero;
    logic [31:0] mem_wdata, mem_rdata, pc_value;
    logic [5:0] opcode, funct;

    mc_datapath dut (
        .clk(clk), .rst(rst), .pc_we(pc_we), .pc_cond_we(pc_cond_we), .ir_we(ir_we),
        .opnd_we(opnd_we), .res_we(res_we), .mdr_we(mdr_we), .rf_we(rf_we),
        .mem_write(mem_write), .addr_from_res(addr_from_res), .opa_from_reg(opa_from_reg),
        .opb_sel(opb_sel), .alu_ctl(alu_ctl), .pc_next_sel(pc_next_sel),
        .wb_from_mdr(wb_from_mdr), .dst_is_rd(dst_is_rd), .mem_word_addr(mem_word_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .opcode(opcode),
        .funct(funct), .alu_zero(alu_zero), .pc_value(pc_value)
    );

    localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                           OP_SUB = 3'b110, OP_SLT = 3'b111;
    localparam int OBS_WORD = 224;

    logic [31:0] mem [256];
    logic [31:0] exp_rf [32];
    logic [31:0] exp_pc;
    int n_chk = 0;
    int n_fail = 0;

    assign mem_rdata = mem[mem_word_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_word_addr[7:0]] <= mem_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic idle();
        {pc_we, pc_cond_we, ir_we, opnd_we, res_we, mdr_we, rf_we, mem_write} = '0;
        {addr_from_res, opa_from_reg, wb_from_mdr, dst_is_rd} = '0;
        opb_sel = 2'b00; pc_next_sel = 2'b00; alu_ctl = OP_ADD;
    endtask

    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            OP_AND: return a & b;
            OP_OR:  return a | b;
            OP_SUB: return a - b;
            OP_SLT: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    // R1: fetch then decode (R2, R3: target latched speculatively)
    task automatic fetch_decode(input logic [31:0] instr);
        mem[exp_pc[9:2]] = instr;
        ir_we = 1; pc_we = 1; opb_sel = 2'b01; alu_ctl = OP_ADD; pc_next_sel = 2'b00;
        tick();
        exp_pc = exp_pc + 32'd4;
        check(pc_value == exp_pc, "R1 pc+4", pc_value, exp_pc);
        opnd_we = 1; res_we = 1; opb_sel = 2'b11; alu_ctl = OP_ADD;
        tick();
    endtask

    // R11
    task automatic jmp(input logic [25:0] tgt);
        fetch_decode({6'h02, tgt});
        pc_we = 1; pc_next_sel = 2'b10;
        tick();
        exp_pc = {exp_pc[31:28], tgt, 2'b00};
        check(pc_value == exp_pc, "R11 jump", pc_value, exp_pc);
    endtask

    task automatic room();
        if (exp_pc >= 32'd400) jmp(26'd0);
    endtask

    // R4, R5
    task automatic lw(input logic [4:0] rt, input logic [15:0] off);
        room();
        fetch_decode({6'h23, 5'd0, rt, off});
        opa_from_reg = 1; opb_sel = 2'b10; res_we = 1; alu_ctl = OP_ADD; tick();
        addr_from_res = 1; mdr_we = 1; tick();
        rf_we = 1; wb_from_mdr = 1; tick();
        if (rt != 0) exp_rf[rt] = mem[off[9:2]];
    endtask

    // R6
    task automatic sw(input logic [4:0] rt, input logic [15:0] off);
        room();
        fetch_decode({6'h2b, 5'd0, rt, off});
        opa_from_reg = 1; opb_sel = 2'b10; res_we = 1; alu_ctl = OP_ADD; tick();
        addr_from_res = 1; mem_write = 1; tick();
    endtask

    // R7, R9
    task automatic rop(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [2:0] op);
        room();
        fetch_decode({6'h00, rs, rt, rd, 5'd0, 6'h20});
        opa_from_reg = 1; opb_sel = 2'b00; alu_ctl = op; res_we = 1; tick();
        rf_we = 1; dst_is_rd = 1; tick();
        if (rd != 0) exp_rf[rd] = alu_ref(op, exp_rf[rs], exp_rf[rt]);
    endtask

    // R3, R10
    task automatic beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
        room();
        fetch_decode({6'h04, rs, rt, off});
        opa_from_reg = 1; opb_sel = 2'b00; alu_ctl = OP_SUB; pc_cond_we = 1; pc_next_sel = 2'b01;
        tick();
        if (exp_rf[rs] == exp_rf[rt]) exp_pc = exp_pc + ({{16{off[15]}}, off} << 2);
        check(pc_value == exp_pc, "R10 branch", pc_value, exp_pc);
    endtask

    task automatic observe(input logic [4:0] r, input string req);
        sw(r, 16'(OBS_WORD * 4));
        check(mem[OBS_WORD] == exp_rf[r], req, mem[OBS_WORD], exp_rf[r]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 32; i++) exp_rf[i] = 32'h0;
        exp_pc = 0;
        for (int i = 1; i < 32; i++) mem[128 + i] = (32'h9E37_79B9 * i) ^ (i << 20);
        mem[128 + 7]  = 32'h8000_0000;
        mem[128 + 8]  = 32'h7FFF_FFFF;
        mem[128 + 9]  = 32'hFFFF_FFFF;
        mem[128 + 10] = 32'hFFFF_FFFF;
        mem[128]      = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R12
        check(pc_value == 0, "R12 reset pc", pc_value, 0);
        check(mem_word_addr == 0, "R12 reset addr", {2'b00, mem_word_addr}, 0);
        observe(5'd3, "R12 reset reg");

        // R2 R4 R5 R6: load every register, store it back
        for (int r = 1; r < 32; r++) lw(5'(r), 16'((128 + r) * 4));
        for (int r = 1; r < 32; r++) observe(5'(r), "R5 load/store");

        // R8: register 0 ignores load and R-type writes
        lw(5'd0, 16'(128 * 4));
        observe(5'd0, "R8 r0 after load");
        rop(5'd1, 5'd2, 5'd0, OP_ADD);
        observe(5'd0, "R8 r0 after rtype");

        // R7 R9: every ALU op over a set of operand pairs
        for (int p = 0; p < 12; p++) begin
            logic [4:0] rs, rt;
            rs = 5'(p + 1);
            rt = 5'(31 - p);
            if (p == 9)  begin rs = 5'd7; rt = 5'd8; end
            if (p == 10) begin rs = 5'd8; rt = 5'd7; end
            if (p == 11) begin rs = 5'd9; rt = 5'd10; end
            for (int o = 0; o < 5; o++) begin
                logic [2:0] op;
                op = (o == 0) ? OP_AND : (o == 1) ? OP_OR : (o == 2) ? OP_ADD :
                     (o == 3) ? OP_SUB : OP_SLT;
                rop(rs, rt, 5'd30, op);
                observe(5'd30, "R7 R9 alu writeback");
            end
        end

        // R3 R10: taken, not taken, backward taken
        jmp(26'd16);
        beq(5'd9, 5'd10, 16'd3);
        beq(5'd1, 5'd2, 16'd3);
        beq(5'd5, 5'd5, 16'hFFFE);
        beq(5'd7, 5'd8, 16'hFFF0);
        jmp(26'd10);

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule